// File: doc/BRIEF.md
# Windowed Temperature Alert Interrupt

The block keeps an upper and a lower temperature limit and tests every valid die-temperature sample against them. The sample is an 8-bit whole-degree Celsius value. When a sample lies outside the allowed window, the block sets a sticky alert. Only a clear command written by the host removes it.

The alert is kept active-low. The block inverts it and registers it on the system clock to give an active-high interrupt for the host. A small register port lets the host write both limits and the clear command. The same port reads back both limits and the alert state.

A clear does not blindly drop the alert. It tests the newest temperature, either the sample arriving in the same cycle or the last one held, against the current limits. If a limit is still violated, the alert stays set.

Top module: `temp_window_alert`

## Requirements
- R1: After reset the upper limit is 255, the lower limit is 0, alert_no is 1 and irq_o is 0.
- R2: A write with wr_addr_i 0 loads the upper limit and a write with wr_addr_i 1 loads the lower limit from wr_data_i. Reading rd_addr_i 0 and 1 returns the upper and lower limit.
- R3: Reading rd_addr_i 2 returns the alert state in bit 0 (1 means active) with bits 7:1 zero. Reading rd_addr_i 3 returns 0.
- R4: A sample with temp_valid_i high and temp_i above the upper limit or below the lower limit drives alert_no low on the next clock edge. Both tests are unsigned. A sample equal to either limit is inside the window.
- R5: Samples presented with temp_valid_i low have no effect on the alert.
- R6: Once set, the alert stays set through in-window samples and limit changes until a clear command is written.
- R7: A clear command is a write of data 0 to wr_addr_i 2. A write of any nonzero value to that address has no effect.
- R8: A clear with no sample in the same cycle re-tests the last valid sample against the current limits. If that sample still violates a limit, the alert remains set; otherwise it clears on the next edge.
- R9: A clear in the same cycle as a valid sample clears the alert only when that new sample is inside the window. A violating sample keeps the alert set.
- R10: Writing new limits alone never sets the alert. Only a valid sample or a re-test on clear can do so.
- R11: irq_o is the inverse of alert_no registered by one clock, so it rises one cycle after alert_no falls and falls one cycle after alert_no rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 upper limit, 1 lower limit, 2 clear |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| temp_valid_i | input | 1 | Temperature sample strobe |
| temp_i | input | 8 | Temperature sample, whole degrees Celsius |
| alert_no | output | 1 | Sticky alert, active low |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
The hardest case to reach is a clear that is refused. The last held sample must violate limits that may have been rewritten after that sample arrived, or a violating sample must land in the same cycle as the clear. Directed sequences set this up on purpose. They raise an alert, move the limits so that the held sample becomes legal or stays illegal, and then clear, with and without a coincident sample. Random stimulus draws limits from a narrow band so that samples, clears and limit writes often fall on or near the window edges.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  localparam int TEMP_W = 8;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_MAX  = 2'd0,
    REG_MIN  = 2'd1,
    REG_CTRL = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import temp_alert_pkg::*;
#(
  parameter int W = TEMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      max_o,
  output logic [W-1:0]      min_o,
  output logic              clr_o
);
  logic [W-1:0] max_q, min_q;
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '1;
      min_q <= '0;
    end else if (wr_en_i) begin
      if (addr == REG_MAX) max_q <= wr_data_i;
      if (addr == REG_MIN) min_q <= wr_data_i;
    end
  end

  assign clr_o = wr_en_i && (addr == REG_CTRL) && (wr_data_i == '0);
  assign max_o = max_q;
  assign min_o = min_q;

  // R2
  max_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == REG_MAX) |=> (max_o == $past(wr_data_i)));
  // R2
  min_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == REG_MIN) |=> (min_o == $past(wr_data_i)));
endmodule

// File: rtl/window_cmp.sv
module window_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] temp_i,
  input  logic [W-1:0] max_i,
  input  logic [W-1:0] min_i,
  output logic         viol_o
);
  assign viol_o = (temp_i > max_i) || (temp_i < min_i);
endmodule

// File: rtl/alert_latch.sv
module alert_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic new_viol_i,  // new sample outside window
  input  logic cur_viol_i,  // newest known temperature outside window
  output logic alert_o,
  output logic alert_no,
  output logic irq_o
);
  logic alert_q, alert_d, irq_q;

  always_comb begin
    if (clr_i) alert_d = cur_viol_i;
    else       alert_d = alert_q | (valid_i & new_viol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      alert_q <= alert_d;
      irq_q   <= ~alert_no;
    end
  end

  assign alert_o  = alert_q;
  assign alert_no = ~alert_q;
  assign irq_o    = irq_q;

  // R4
  set_on_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && new_viol_i) |=> !alert_no);
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_o && !clr_i) |=> alert_o);
  // R8
  clear_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cur_viol_i) |=> alert_no);
  // R11
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == !$past(alert_no)));
endmodule

// File: rtl/temp_window_alert.sv
module temp_window_alert
  import temp_alert_pkg::*;
#(
  parameter int W = TEMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  input  logic              temp_valid_i,
  input  logic [W-1:0]      temp_i,
  output logic              alert_no,
  output logic              irq_o
);
  logic [W-1:0] max_w, min_w, last_q, cur_temp;
  logic         have_q, clr_w, new_viol, held_viol, cur_viol, alert_w;

  thr_regs #(.W(W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .max_o(max_w), .min_o(min_w), .clr_o(clr_w)
  );

  // one comparator for the arriving sample, one for the newest known one
  window_cmp #(.W(W)) i_cmp_new (
    .temp_i(temp_i), .max_i(max_w), .min_i(min_w), .viol_o(new_viol)
  );
  window_cmp #(.W(W)) i_cmp_cur (
    .temp_i(cur_temp), .max_i(max_w), .min_i(min_w), .viol_o(held_viol)
  );

  assign cur_temp = temp_valid_i ? temp_i : last_q;
  assign cur_viol = (temp_valid_i | have_q) & held_viol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (temp_valid_i) begin
      last_q <= temp_i;
      have_q <= 1'b1;
    end
  end

  alert_latch i_alert (
    .clk_i, .rst_ni, .clr_i(clr_w), .valid_i(temp_valid_i),
    .new_viol_i(new_viol), .cur_viol_i(cur_viol),
    .alert_o(alert_w), .alert_no(alert_no), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      REG_MAX:  rd_data_o = max_w;
      REG_MIN:  rd_data_o = min_w;
      REG_CTRL: rd_data_o = {{(W-1){1'b0}}, alert_w};
      default:  rd_data_o = '0;
    endcase
  end

  // R9
  clr_viol_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && temp_valid_i && new_viol) |=> !alert_no);
  // R3
  rd_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd2) |-> (rd_data_o == {{(W-1){1'b0}}, !alert_no}));
endmodule

// File: tb/test_temp_window_alert.sv
module test_temp_window_alert;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, valid = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, temp = 0, rd_data;
  logic       alert_n, irq;

  int n_chk = 0, n_fail = 0;
  int m_max = 255, m_min = 0, m_last = 0;
  bit m_have = 0, m_alert = 0, m_irq = 0;

  temp_window_alert i_temp_window_alert (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .temp_valid_i(valid), .temp_i(temp), .alert_no(alert_n), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit viol(int t);
    return (t > m_max) || (t < m_min);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, advance the model, check outputs
  task automatic cyc(bit we, int wa, int wd, bit v, int t, string req);
    bit clr, nxt;
    @(negedge clk);
    wr_en = we; wr_addr = 2'(wa); wr_data = 8'(wd); valid = v; temp = 8'(t);
    clr = we && wa == 2 && wd == 0;
    if (clr) nxt = (v || m_have) && viol(v ? t : m_last);
    else     nxt = m_alert | (v && viol(t));
    @(posedge clk);
    m_irq = m_alert;
    m_alert = nxt;
    if (we && wa == 0) m_max = wd;
    if (we && wa == 1) m_min = wd;
    if (v) begin m_last = t; m_have = 1; end
    #1;
    wr_en = 0; valid = 0;
    chk(alert_n == !m_alert, req, alert_n, !m_alert);
    chk(irq == m_irq, "R11", irq, m_irq);
  endtask

  task automatic rd_all();
    rd_addr = 0; #1 chk(rd_data == 8'(m_max), "R2", rd_data, m_max);
    rd_addr = 1; #1 chk(rd_data == 8'(m_min), "R2", rd_data, m_min);
    rd_addr = 2; #1 chk(rd_data == {7'b0, m_alert}, "R3", rd_data, m_alert);
    rd_addr = 3; #1 chk(rd_data == 0, "R3", rd_data, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    chk(alert_n == 1, "R1", alert_n, 1);
    chk(irq == 0, "R1", irq, 0);
    rd_all();
    rst_n = 1;
    // R4 equal to limits is inside
    cyc(1, 0, 80, 0, 0, "R2");
    cyc(1, 1, 20, 0, 0, "R2");
    rd_all();
    cyc(0, 0, 0, 1, 80, "R4");
    cyc(0, 0, 0, 1, 20, "R4");
    // R5 invalid samples ignored
    cyc(0, 0, 0, 0, 200, "R5");
    cyc(0, 0, 0, 0, 5, "R5");
    // R4 above window
    cyc(0, 0, 0, 1, 81, "R4");
    cyc(0, 0, 0, 0, 0, "R11");
    rd_all();
    // R6 sticky through in-window sample
    cyc(0, 0, 0, 1, 50, "R6");
    // R7 nonzero write to clear address ignored
    cyc(1, 2, 1, 0, 0, "R7");
    // R8 clear with held in-window sample
    cyc(1, 2, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, "R11");
    // R4 below, then R8 clear refused on held violation
    cyc(0, 0, 0, 1, 19, "R4");
    cyc(1, 2, 0, 0, 0, "R8");
    // R10 relax limit: no effect until clear, then clear works
    cyc(1, 1, 10, 0, 0, "R10");
    cyc(1, 2, 0, 0, 0, "R8");
    // R10 tighten limits: held sample now illegal, no alert
    cyc(1, 0, 15, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, "R10");
    cyc(1, 2, 0, 0, 0, "R8");
    // R9 clear with same-cycle samples
    cyc(1, 2, 0, 1, 12, "R9");
    cyc(0, 0, 0, 1, 3, "R4");
    cyc(1, 2, 0, 1, 99, "R9");
    cyc(1, 2, 0, 1, 15, "R9");
    rd_all();
    // random phase, narrow limits
    for (int i = 0; i < 2000; i++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: cyc(1, 0, $urandom_range(100, 140), $urandom_range(0, 1), $urandom_range(80, 160), "R2");
        1: cyc(1, 1, $urandom_range(90, 120), $urandom_range(0, 1), $urandom_range(80, 160), "R2");
        2: cyc(1, 2, 0, $urandom_range(0, 1), $urandom_range(80, 160), "R9");
        3: cyc(1, 2, $urandom_range(1, 255), 0, 0, "R7");
        4: cyc(1, 3, $urandom_range(0, 255), 1, $urandom_range(80, 160), "R4");
        default: cyc(0, 0, 0, $urandom_range(0, 1), $urandom_range(80, 160), "R4");
      endcase
      if (i % 50 == 0) rd_all();
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule